// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one private cache that sits on a shared snooping bus. It takes load and store requests from the local core. For each request it either completes the request at once from the line's current state, or it opens a bus transaction and completes the request when the bus grants it. At the same time it watches the requests that other caches place on the bus. It reports whether it holds the snooped line, and it raises a flush or write-back strobe when dirty data has to leave the cache.

Each line is in one of four states: Modified, Exclusive, Shared or Invalid. A store to a line held as the only clean copy (Exclusive) becomes Modified at once, with no bus traffic. A read fill lands in Exclusive or Shared, chosen from the bus shared line that is sampled in the grant cycle. Snoops take priority: a local request that targets the line being snooped in the same cycle waits. Data storage, bus arbitration and memory are outside the block. It produces only handshakes and state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Every line holds a 2-bit state, encoded I=0, S=1, E=2, M=3. Reset puts every line in I and clears all outputs, so the first load to any line is a miss.
- R2: A load to a line in M, E or S completes in the same cycle (req_ready=1). It raises no bus request and leaves the state unchanged.
- R3: A load to an I line raises bus_req_valid with bus_req_op=0 (read) from the next cycle on. In the cycle bus_gnt is high, req_ready is 1 and the line becomes S if bus_shared_in=1, or E if bus_shared_in=0.
- R4: A store to an E line completes in the same cycle with no bus request, and the line becomes M.
- R5: A store to an M line completes in the same cycle with no bus request, and the line stays M.
- R6: A store to an S or I line raises bus_req_valid with bus_req_op=1 (read-for-ownership) from the next cycle on. On grant, req_ready is 1 and the line becomes M.
- R7: A snooped read (snoop_op=0) that hits an M line raises snoop_flush in the same cycle, and the line becomes S.
- R8: A snooped read that hits an E or S line leaves it in S and raises neither snoop_flush nor snoop_wb.
- R9: A snooped read-for-ownership (snoop_op=1) that hits a valid line moves it to I. If the line was M, snoop_wb is raised in the same cycle.
- R10: snoop_shared is 1 in a cycle exactly when snoop_valid is 1 and the snooped line is in M, E or S.
- R11: While snoop_valid is 1 with snoop_idx equal to the line of the local request, that request does not complete (req_ready=0, including in a grant cycle). The snoop takes effect first. A snoop to a different line does not hold the request back.
- R12: Once raised, bus_req_valid, bus_req_op and bus_req_idx stay unchanged until the cycle in which bus_gnt is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present; held until req_ready |
| req_store | input | 1 | 1 = store, 0 = load |
| req_idx | input | IDX_W | Line index of the local request |
| req_ready | output | 1 | Local request completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 1 | 0 = read, 1 = read-for-ownership |
| bus_req_idx | output | IDX_W | Line index of the bus transaction |
| bus_gnt | input | 1 | Bus transaction granted and performed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with bus_gnt) |
| snoop_valid | input | 1 | Another cache's bus transaction is visible |
| snoop_op | input | 1 | 0 = read, 1 = read-for-ownership |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_flush | output | 1 | Dirty line supplied to memory on a snooped read |
| snoop_wb | output | 1 | Dirty line written back before invalidation |

## Verification
The bench checks that a fill lands in E or S according to the shared line sampled in the grant cycle, not in an earlier cycle. A design that sampled the wrong cycle would later issue a needless read-for-ownership, or it would store silently to a copy other caches still hold. It also covers a snoop and a local request to the same line in the same cycle, both in the idle state and in a grant cycle. A design without the snoop priority would complete the request on stale state, or it would lose one of two updates written in the same cycle. Further checks cover a snooped read on M, which must raise flush and go to S and not to I, and a grant held off for several cycles, during which the bus request must not change.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   typedef enum logic {
      OP_RD  = 1'b0,
      OP_RDX = 1'b1
   } bus_op_e;

   typedef enum logic {
      LF_IDLE = 1'b0,
      LF_WAIT = 1'b1
   } loc_fsm_e;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
   import mesi_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           snp_we,
   input  logic     [IDX_W-1:0]           snp_idx,
   input  line_st_e                       snp_st,
   input  logic                           loc_we,
   input  logic     [IDX_W-1:0]           loc_idx,
   input  line_st_e                       loc_st,
   output line_st_e [NUM_LINES-1:0]       line_st
);

   initial begin
      assert (NUM_LINES >= 2 && (1 << IDX_W) == NUM_LINES)
         else $error("mesi_state_array: NUM_LINES must equal 2**IDX_W");
   end

   // One register per line; the snoop write port wins over the local port.
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_st[g] <= ST_I;
         end else if (snp_we && snp_idx == IDX_W'(g)) begin
            line_st[g] <= snp_st;
         end else if (loc_we && loc_idx == IDX_W'(g)) begin
            line_st[g] <= loc_st;
         end
      end
   end

   // R11: the local side never writes the line a snoop is updating.
   assert_no_port_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_we && loc_we) |-> (snp_idx != loc_idx));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
(
   input  logic     snoop_valid,
   input  bus_op_e  snoop_op,
   input  line_st_e snp_cur,
   output logic     snoop_shared,
   output logic     snoop_flush,
   output logic     snoop_wb,
   output logic     snp_we,
   output line_st_e snp_nxt
);

   logic held;
   logic dirty;

   always_comb begin
      held         = snoop_valid && (snp_cur != ST_I);
      dirty        = held && (snp_cur == ST_M);
      snoop_shared = held;
      snoop_flush  = dirty && (snoop_op == OP_RD);
      snoop_wb     = dirty && (snoop_op == OP_RDX);
      snp_we       = held;
      snp_nxt      = (snoop_op == OP_RDX) ? ST_I : ST_S;
   end

   // R9 / R7: a strobe for dirty data never comes without holding the line.
   assert_dirty_strobe_held_R9: assert final
      (!(snoop_flush || snoop_wb) || snoop_shared);

endmodule

// File: rtl/mesi_local_ctrl.sv
module mesi_local_ctrl
   import mesi_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_store,
   input  logic [IDX_W-1:0] req_idx,
   input  line_st_e         req_cur,
   input  logic             snoop_valid,
   input  logic [IDX_W-1:0] snoop_idx,
   input  logic             bus_gnt,
   input  logic             bus_shared_in,
   output logic             req_ready,
   output logic             bus_req_valid,
   output bus_op_e          bus_req_op,
   output logic [IDX_W-1:0] bus_req_idx,
   output logic             loc_we,
   output logic [IDX_W-1:0] loc_idx,
   output line_st_e         loc_st
);

   initial begin
      assert (IDX_W >= 1) else $error("mesi_local_ctrl: IDX_W must be at least 1");
   end

   loc_fsm_e         fsm_q, fsm_d;
   bus_op_e          op_q, op_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             blocked;

   always_comb begin
      fsm_d     = fsm_q;
      op_d      = op_q;
      idx_d     = idx_q;
      req_ready = 1'b0;
      loc_we    = 1'b0;
      loc_idx   = req_idx;
      loc_st    = req_cur;
      blocked   = 1'b0;
      case (fsm_q)
         LF_IDLE: begin
            blocked = snoop_valid && (snoop_idx == req_idx);
            if (req_valid && !blocked) begin
               if (!req_store) begin
                  if (req_cur == ST_I) begin
                     fsm_d = LF_WAIT;
                     op_d  = OP_RD;
                     idx_d = req_idx;
                  end else begin
                     req_ready = 1'b1;
                  end
               end else begin
                  case (req_cur)
                     ST_M: req_ready = 1'b1;
                     ST_E: begin
                        req_ready = 1'b1;
                        loc_we    = 1'b1;
                        loc_st    = ST_M;
                     end
                     default: begin
                        fsm_d = LF_WAIT;
                        op_d  = OP_RDX;
                        idx_d = req_idx;
                     end
                  endcase
               end
            end
         end
         LF_WAIT: begin
            blocked = snoop_valid && (snoop_idx == idx_q);
            loc_idx = idx_q;
            if (bus_gnt && !blocked) begin
               req_ready = 1'b1;
               loc_we    = 1'b1;
               fsm_d     = LF_IDLE;
               if (op_q == OP_RDX) begin
                  loc_st = ST_M;
               end else begin
                  loc_st = bus_shared_in ? ST_S : ST_E;
               end
            end
         end
         default: fsm_d = LF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q <= LF_IDLE;
         op_q  <= OP_RD;
         idx_q <= '0;
      end else begin
         fsm_q <= fsm_d;
         op_q  <= op_d;
         idx_q <= idx_d;
      end
   end

   assign bus_req_valid = (fsm_q == LF_WAIT);
   assign bus_req_op    = op_q;
   assign bus_req_idx   = idx_q;

   // R12: a pending bus request holds still until granted.
   assert_bus_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_gnt) |=>
         (bus_req_valid && $stable(bus_req_idx) && $stable(bus_req_op)));

   // R6: a store to a Shared line leads to a read-for-ownership request.
   assert_store_shared_rdx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req_valid && req_valid && req_store && req_cur == ST_S &&
       !(snoop_valid && snoop_idx == req_idx)) |=>
         (bus_req_valid && bus_req_op == OP_RDX));

   // R2: a load hit never reaches the bus.
   assert_load_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req_valid && req_valid && !req_store && req_cur != ST_I && req_ready) |=>
         !bus_req_valid);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int NUM_LINES = 16,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_store,
   input  logic [IDX_W-1:0] req_idx,
   output logic             req_ready,
   output logic             bus_req_valid,
   output logic             bus_req_op,
   output logic [IDX_W-1:0] bus_req_idx,
   input  logic             bus_gnt,
   input  logic             bus_shared_in,
   input  logic             snoop_valid,
   input  logic             snoop_op,
   input  logic [IDX_W-1:0] snoop_idx,
   output logic             snoop_shared,
   output logic             snoop_flush,
   output logic             snoop_wb
);

   initial begin
      assert (NUM_LINES >= 2 && (1 << IDX_W) == NUM_LINES)
         else $error("mesi_line_ctrl: NUM_LINES must be a power of two, at least 2");
   end

   line_st_e [NUM_LINES-1:0] line_st;
   line_st_e                 req_cur;
   line_st_e                 snp_cur;
   line_st_e                 snp_nxt;
   line_st_e                 loc_st;
   logic                     snp_we;
   logic                     loc_we;
   logic [IDX_W-1:0]         loc_idx;
   bus_op_e                  snp_op_e;
   bus_op_e                  bus_op_int;

   assign req_cur    = line_st[req_idx];
   assign snp_cur    = line_st[snoop_idx];
   assign snp_op_e   = bus_op_e'(snoop_op);
   assign bus_req_op = bus_op_int;

   mesi_snoop_resp u_snoop (
      .snoop_valid (snoop_valid),
      .snoop_op    (snp_op_e),
      .snp_cur     (snp_cur),
      .snoop_shared(snoop_shared),
      .snoop_flush (snoop_flush),
      .snoop_wb    (snoop_wb),
      .snp_we      (snp_we),
      .snp_nxt     (snp_nxt)
   );

   mesi_local_ctrl #(.IDX_W(IDX_W)) u_local (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_store    (req_store),
      .req_idx      (req_idx),
      .req_cur      (req_cur),
      .snoop_valid  (snoop_valid),
      .snoop_idx    (snoop_idx),
      .bus_gnt      (bus_gnt),
      .bus_shared_in(bus_shared_in),
      .req_ready    (req_ready),
      .bus_req_valid(bus_req_valid),
      .bus_req_op   (bus_op_int),
      .bus_req_idx  (bus_req_idx),
      .loc_we       (loc_we),
      .loc_idx      (loc_idx),
      .loc_st       (loc_st)
   );

   mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .snp_we (snp_we),
      .snp_idx(snoop_idx),
      .snp_st (snp_nxt),
      .loc_we (loc_we),
      .loc_idx(loc_idx),
      .loc_st (loc_st),
      .line_st(line_st)
   );

   // R3: a granted read fill lands in S or E according to the shared line.
   assert_fill_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_gnt && bus_req_op == 1'b0 &&
       !(snoop_valid && snoop_idx == bus_req_idx)) |=>
         (line_st[$past(bus_req_idx)] == ($past(bus_shared_in) ? ST_S : ST_E)));

   // R4: a store to an Exclusive line upgrades silently.
   assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req_valid && req_valid && req_store && req_cur == ST_E &&
       !(snoop_valid && snoop_idx == req_idx)) |=>
         (line_st[$past(req_idx)] == ST_M && !bus_req_valid));

   // R7: a snooped read on a Modified line flushes.
   assert_flush_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && !snoop_op && snp_cur == ST_M) |-> snoop_flush);

   // R7: and the line drops to Shared.
   assert_mod_to_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && !snoop_op && snp_cur == ST_M) |=>
         (line_st[$past(snoop_idx)] == ST_S));

   // R9: a snooped read-for-ownership leaves the line Invalid.
   assert_rdx_invalidates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && snoop_op) |=> (line_st[$past(snoop_idx)] == ST_I));

   // R10: the shared report only appears with a snoop.
   assert_shared_needs_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_shared |-> snoop_valid);

   // R11: no idle-state completion on a line under snoop.
   assert_snoop_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && req_valid && !bus_req_valid && snoop_idx == req_idx) |-> !req_ready);

endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

   localparam int NL = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 0, req_store = 0, bus_gnt = 0, bus_shared_in = 0;
   logic          snoop_valid = 0, snoop_op = 0;
   logic [IW-1:0] req_idx = '0, snoop_idx = '0;
   logic          req_ready, bus_req_valid, bus_req_op;
   logic [IW-1:0] bus_req_idx;
   logic          snoop_shared, snoop_flush, snoop_wb;

   always #4 clk = ~clk;

   mesi_line_ctrl #(.NUM_LINES(NL)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_idx(req_idx), .req_ready(req_ready),
      .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_idx(bus_req_idx),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_idx(snoop_idx),
      .snoop_shared(snoop_shared), .snoop_flush(snoop_flush), .snoop_wb(snoop_wb)
   );

   // Reference model: 0=I 1=S 2=E 3=M
   int ms[NL];
   int m_wait = 0, m_op = 0, m_idx = 0;
   int n_chk = 0, n_err = 0;
   bit done = 0;
   int h_st = 0, h_idx = 0;

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic rv, input logic rs, input int ri, input logic sv, input logic so,
                      input int si, input logic g, input logic sh, input string tag);
      int e_rdy, e_sh, e_fl, e_wb, col, cur, nws, nwi;
      req_valid = rv; req_store = rs; req_idx = IW'(ri);
      snoop_valid = sv; snoop_op = so; snoop_idx = IW'(si);
      bus_gnt = g; bus_shared_in = sh;
      #1;
      e_sh = (sv && ms[si] != 0) ? 1 : 0;
      e_fl = (sv && ms[si] == 3 && !so) ? 1 : 0;
      e_wb = (sv && ms[si] == 3 && so) ? 1 : 0;
      col  = sv && (si == (m_wait ? m_idx : ri));
      cur  = ms[ri];
      e_rdy = 0; nws = m_wait; nwi = m_idx;
      if (!m_wait && rv && !col) begin
         if (!rs && cur != 0) e_rdy = 1;
         if (rs && cur >= 2) e_rdy = 1;
      end
      if (m_wait && g && !col) e_rdy = 1;
      chk(tag, "req_ready", 8'(req_ready), 8'(e_rdy));
      chk(tag, "bus_req_valid", 8'(bus_req_valid), 8'(m_wait));
      if (m_wait) begin
         chk(tag, "bus_req_op", 8'(bus_req_op), 8'(m_op));
         chk(tag, "bus_req_idx", 8'(bus_req_idx), 8'(m_idx));
      end
      chk(tag, "snoop_shared", 8'(snoop_shared), 8'(e_sh));
      chk(tag, "snoop_flush", 8'(snoop_flush), 8'(e_fl));
      chk(tag, "snoop_wb", 8'(snoop_wb), 8'(e_wb));
      @(posedge clk);
      if (sv && ms[si] != 0) ms[si] = so ? 0 : 1;
      if (!m_wait && rv && !col) begin
         if (!rs && cur == 0) begin m_wait = 1; m_op = 0; m_idx = ri; end
         else if (rs && cur == 2) ms[ri] = 3;
         else if (rs && cur <= 1) begin m_wait = 1; m_op = 1; m_idx = ri; end
      end else if (m_wait && g && !col) begin
         ms[nwi] = m_op ? 3 : (sh ? 1 : 2);
         m_wait = 0;
      end
      if (nws == 0) nws = 0;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) ms[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");
      // R1/R3: first load is a miss; lone fill goes E
      cyc(1, 0, 0, 0, 0, 0, 0, 0, "R1");
      cyc(1, 0, 0, 0, 0, 0, 1, 0, "R3");
      cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      cyc(1, 1, 0, 0, 0, 0, 0, 0, "R4");
      cyc(1, 1, 0, 0, 0, 0, 0, 0, "R5");
      cyc(0, 0, 0, 1, 0, 0, 0, 0, "R7");
      cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      cyc(1, 1, 0, 0, 0, 0, 0, 0, "R6");
      cyc(1, 1, 0, 0, 0, 0, 1, 0, "R6");
      cyc(0, 0, 0, 1, 1, 0, 0, 0, "R9");
      cyc(0, 0, 0, 1, 0, 0, 0, 0, "R10");
      // shared fill
      cyc(1, 0, 1, 0, 0, 0, 0, 0, "R3");
      cyc(1, 0, 1, 0, 0, 0, 1, 1, "R3");
      cyc(0, 0, 0, 1, 0, 1, 0, 0, "R8");
      cyc(0, 0, 0, 1, 1, 1, 0, 0, "R9");
      cyc(0, 0, 0, 1, 0, 1, 0, 0, "R10");
      // E to S on snooped read
      cyc(1, 0, 2, 0, 0, 0, 0, 0, "R3");
      cyc(1, 0, 2, 0, 0, 0, 1, 0, "R3");
      cyc(0, 0, 0, 1, 0, 2, 0, 0, "R8");
      cyc(0, 0, 0, 1, 0, 2, 0, 0, "R8");
      // store miss with a delayed grant
      cyc(1, 1, 3, 0, 0, 0, 0, 0, "R6");
      for (int k = 0; k < 3; k++) cyc(1, 1, 3, 0, 0, 0, 0, 0, "R12");
      cyc(1, 1, 3, 0, 0, 0, 1, 0, "R6");
      // collisions
      cyc(1, 0, 3, 1, 0, 3, 0, 0, "R11");
      cyc(1, 0, 3, 0, 0, 0, 0, 0, "R11");
      cyc(1, 0, 4, 0, 0, 0, 0, 0, "R11");
      cyc(1, 0, 4, 1, 1, 4, 1, 0, "R11");
      cyc(1, 0, 4, 0, 0, 0, 1, 0, "R11");
      cyc(1, 0, 4, 1, 0, 3, 0, 0, "R11");
      idle("R1");
      // randomized traffic on a few lines
      for (int n = 0; n < 3000; n++) begin
         logic rv, rs, sv, so, g, sh;
         int ri, si;
         if (m_wait) begin
            rv = 1; rs = logic'(h_st); ri = h_idx;
         end else begin
            rv = logic'($urandom_range(0, 1));
            rs = logic'($urandom_range(0, 1));
            ri = int'($urandom_range(0, 3));
            h_st = int'(rs); h_idx = ri;
         end
         sv = ($urandom_range(0, 2) == 0);
         so = logic'($urandom_range(0, 1));
         si = int'($urandom_range(0, 3));
         g  = logic'($urandom_range(0, 1));
         sh = logic'($urandom_range(0, 1));
         cyc(rv, rs, ri, sv, so, si, g, sh, "R11");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule